// File: doc/BRIEF.md
# Micro-TLB with Selective Invalidation

This block is a small, fully associative address-translation cache that sits in front of a larger set-associative main TLB. A requester presents a virtual page number and an address-space identifier. On a hit, the physical frame and the permission bits come back in the same cycle. On a miss, the block stalls the requester and raises a refill request towards the main TLB. It then installs the response in the slot chosen by a round-robin pointer.

The entries are kept when the main TLB overwrites one of its own victims during miss handling. Because of this, the higher associativity of the micro-TLB hides conflicts in the main TLB's sets. Everything is cleared only by an explicit flush. A flush comes either from a main-TLB write that is marked as flushing, or from a standalone invalidate command. The entry count is a parameter: the data-side instance uses 8 entries and the instruction-side instance uses 4. Permission bits are passed through without interpretation.

Top module: `utlb_cache`

## Requirements
- R1: After a synchronous reset, every entry is invalid, `lk_hit` is low for any lookup, and `fill_req` is low.
- R2: A lookup that matches a valid entry raises `lk_hit` and drives that entry's frame and permissions in the same cycle, with `lk_stall` low.
- R3: An entry matches when its stored virtual page equals `lk_vpage` and either its ASID equals `lk_asid` or its global bit is set. A non-global entry never matches a different ASID.
- R4: A lookup with `lk_valid` high and no match drives `lk_stall` high. From the next cycle on, `fill_req` is high with `fill_vpage`/`fill_asid` holding the missed page and ASID. It stays high until a cycle with `fill_rsp_valid` high, which installs the entry. The same held lookup hits in the following cycle.
- R5: Refills take slots in round-robin order. With all slots filled, the next refill replaces the entry filled longest ago, and the other entries keep hitting.
- R6: A main-TLB write with `main_wr` high and `main_wr_flush` low leaves every entry valid and hitting.
- R7: A main-TLB write with `main_wr_flush` high, or `inval_all` high, invalidates all entries as of the next cycle.
- R8: When a flush coincides with `fill_rsp_valid`, the flush wins. The response is discarded, the held lookup still misses, and a new refill request is raised.
- R9: The entry count is the parameter ENTRIES. A 4-entry instance keeps four pages and evicts the first one on its fifth refill. In an 8-entry instance, three pages that would collide in one 2-way main-TLB set all hit together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_vpage | input | 19 | Lookup virtual page number |
| lk_asid | input | 8 | Lookup address-space identifier |
| lk_hit | output | 1 | Lookup hit (combinational) |
| lk_stall | output | 1 | Lookup missed; requester must hold |
| lk_frame | output | 19 | Physical frame of the hitting entry |
| lk_perm | output | 6 | Permission bits of the hitting entry |
| fill_req | output | 1 | Refill request towards the main TLB |
| fill_vpage | output | 19 | Virtual page being refilled |
| fill_asid | output | 8 | ASID being refilled |
| fill_rsp_valid | input | 1 | Refill response valid |
| fill_rsp_frame | input | 19 | Refill response frame |
| fill_rsp_perm | input | 6 | Refill response permissions |
| fill_rsp_global | input | 1 | Refill response global flag |
| main_wr | input | 1 | Main TLB performed a write |
| main_wr_flush | input | 1 | That write is a flushing write |
| inval_all | input | 1 | Standalone invalidate command |

## Verification
Some properties are checked by assertions on every cycle:
- a flush empties the valid set;
- a cycle with neither flush nor refill leaves the valid set unchanged;
- a refill request only rises after a missed lookup and stays up until answered;
- the round-robin pointer moves on each installed refill.

Other behaviour can only be shown by the bench's scenarios:
- the tag match, including the ASID and global rules;
- the frame returned on a hit;
- which page round-robin replacement evicts;
- the discarded refill when flush and response coincide;
- the eviction point of the 4-entry configuration.

// File: rtl/utlb_pkg.sv
package utlb_pkg;

    localparam int VPN_W  = 19;
    localparam int ASID_W = 8;
    localparam int PFN_W  = 19;
    localparam int PERM_W = 6;

    typedef struct packed {
        logic [VPN_W-1:0]  vpage;
        logic [ASID_W-1:0] asid;
        logic              glb;
    } utlb_tag_t;

    typedef struct packed {
        logic [PFN_W-1:0]  frame;
        logic [PERM_W-1:0] perm;
    } utlb_data_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } utlb_state_e;

    function automatic logic tag_hits(utlb_tag_t t,
                                      logic [VPN_W-1:0] vp,
                                      logic [ASID_W-1:0] as);
        return (t.vpage == vp) && (t.glb || (t.asid == as));
    endfunction

endpackage

// File: rtl/utlb_rr_ptr.sv
module utlb_rr_ptr
    import utlb_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic                                       clk,
    input  logic                                       rst,
    input  logic                                       adv,
    output logic [((ENTRIES > 1) ? $clog2(ENTRIES) : 1)-1:0] ptr
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (adv)
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end

    // R5: every installed refill moves the victim pointer on
    a_r5_ptr_moves: assert property (@(posedge clk) disable iff (rst)
        adv |=> (ptr != $past(ptr)));

endmodule

// File: rtl/utlb_entry_array.sv
module utlb_entry_array
    import utlb_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic                                       clk,
    input  logic                                       rst,
    input  logic                                       flush,
    input  logic                                       wr_en,
    input  logic [((ENTRIES > 1) ? $clog2(ENTRIES) : 1)-1:0] wr_idx,
    input  utlb_tag_t                                  wr_tag,
    input  utlb_data_t                                 wr_data,
    input  logic [VPN_W-1:0]                           lk_vpage,
    input  logic [ASID_W-1:0]                          lk_asid,
    output logic [ENTRIES-1:0]                         match,
    output utlb_data_t                                 rd_data
);
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int DATA_W = $bits(utlb_data_t);

    utlb_tag_t          tag_q  [ENTRIES];
    utlb_data_t         data_q [ENTRIES];
    logic [ENTRIES-1:0] valid_q;

    // Valid bits: flush has priority over an install in the same cycle.
    always_ff @(posedge clk) begin
        if (rst || flush)
            valid_q <= '0;
        else if (wr_en)
            valid_q[wr_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                tag_q[i]  <= wr_tag;
                data_q[i] <= wr_data;
            end
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = valid_q[g] && tag_hits(tag_q[g], lk_vpage, lk_asid);
    end

    // AND-OR read mux over the (at most one-hot) match vector.
    always_comb begin
        logic [DATA_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i])
                acc = acc | data_q[i];
        end
        rd_data = utlb_data_t'(acc);
    end

    // R7: a flush leaves no valid entry behind
    a_r7_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_q == '0));

    // R6: without flush or install the valid set is untouched
    a_r6_quiet_keeps: assert property (@(posedge clk) disable iff (rst)
        (!flush && !wr_en) |=> (valid_q == $past(valid_q)));

endmodule

// File: rtl/utlb_refill_ctl.sv
module utlb_refill_ctl
    import utlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic              lk_hit,
    input  logic [VPN_W-1:0]  lk_vpage,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              rsp_valid,
    input  logic              flush,
    output logic              fill_req,
    output logic [VPN_W-1:0]  fill_vpage,
    output logic [ASID_W-1:0] fill_asid,
    output logic              commit
);
    utlb_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            fill_vpage <= '0;
            fill_asid  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (lk_valid && !lk_hit) begin
                    state_q    <= ST_WAIT;
                    fill_vpage <= lk_vpage;
                    fill_asid  <= lk_asid;
                end
                ST_WAIT: if (rsp_valid)
                    state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign fill_req = (state_q == ST_WAIT);
    // R8: a coincident flush throws the response away
    assign commit   = fill_req && rsp_valid && !flush;

    // R4: an open request stays up until answered
    a_r4_req_held: assert property (@(posedge clk) disable iff (rst)
        (fill_req && !rsp_valid) |=> fill_req);

    // R4: a request only opens after a missed lookup
    a_r4_req_after_miss: assert property (@(posedge clk) disable iff (rst)
        $rose(fill_req) |-> $past(lk_valid && !lk_hit));

endmodule

// File: rtl/utlb_cache.sv
module utlb_cache
    import utlb_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpage,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              lk_hit,
    output logic              lk_stall,
    output logic [PFN_W-1:0]  lk_frame,
    output logic [PERM_W-1:0] lk_perm,
    output logic              fill_req,
    output logic [VPN_W-1:0]  fill_vpage,
    output logic [ASID_W-1:0] fill_asid,
    input  logic              fill_rsp_valid,
    input  logic [PFN_W-1:0]  fill_rsp_frame,
    input  logic [PERM_W-1:0] fill_rsp_perm,
    input  logic              fill_rsp_global,
    input  logic              main_wr,
    input  logic              main_wr_flush,
    input  logic              inval_all
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic               flush;
    logic               commit;
    logic [IDX_W-1:0]   victim;
    logic [ENTRIES-1:0] match;
    utlb_data_t         rd_data;
    utlb_tag_t          new_tag;
    utlb_data_t         new_data;

    // R6/R7: only a flushing write or the invalidate command clears
    assign flush = (main_wr && main_wr_flush) || inval_all;

    assign new_tag  = '{vpage: fill_vpage, asid: fill_asid, glb: fill_rsp_global};
    assign new_data = '{frame: fill_rsp_frame, perm: fill_rsp_perm};

    utlb_entry_array #(.ENTRIES(ENTRIES)) u_array (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .wr_en    (commit),
        .wr_idx   (victim),
        .wr_tag   (new_tag),
        .wr_data  (new_data),
        .lk_vpage (lk_vpage),
        .lk_asid  (lk_asid),
        .match    (match),
        .rd_data  (rd_data)
    );

    utlb_rr_ptr #(.ENTRIES(ENTRIES)) u_victim (
        .clk (clk),
        .rst (rst),
        .adv (commit),
        .ptr (victim)
    );

    utlb_refill_ctl u_refill (
        .clk        (clk),
        .rst        (rst),
        .lk_valid   (lk_valid),
        .lk_hit     (lk_hit),
        .lk_vpage   (lk_vpage),
        .lk_asid    (lk_asid),
        .rsp_valid  (fill_rsp_valid),
        .flush      (flush),
        .fill_req   (fill_req),
        .fill_vpage (fill_vpage),
        .fill_asid  (fill_asid),
        .commit     (commit)
    );

    assign lk_hit   = lk_valid && (|match);
    assign lk_stall = lk_valid && !(|match);
    assign lk_frame = rd_data.frame;
    assign lk_perm  = rd_data.perm;

endmodule

// File: tb/test_utlb_cache.sv
`timescale 1ns/1ps
module test_utlb_cache;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0, lk_valid_s = 1'b0;
    logic [18:0] lk_vpage = '0;
    logic [7:0]  lk_asid = '0;
    logic        fill_rsp_valid = 1'b0, fill_rsp_global = 1'b0;
    logic [18:0] fill_rsp_frame = '0;
    logic [5:0]  fill_rsp_perm = '0;
    logic        main_wr = 1'b0, main_wr_flush = 1'b0, inval_all = 1'b0;

    logic        lk_hit, lk_stall, fill_req;
    logic [18:0] lk_frame, fill_vpage;
    logic [5:0]  lk_perm;
    logic [7:0]  fill_asid;
    logic        lk_hit_s, lk_stall_s, fill_req_s;
    logic [18:0] lk_frame_s, fill_vpage_s;
    logic [5:0]  lk_perm_s;
    logic [7:0]  fill_asid_s;

    int n_checks = 0;
    int n_fail   = 0;
    logic small_sel = 1'b0;

    always #4 clk = ~clk;

    utlb_cache #(.ENTRIES(8)) i_utlb_cache (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vpage(lk_vpage), .lk_asid(lk_asid),
        .lk_hit(lk_hit), .lk_stall(lk_stall), .lk_frame(lk_frame), .lk_perm(lk_perm),
        .fill_req(fill_req), .fill_vpage(fill_vpage), .fill_asid(fill_asid),
        .fill_rsp_valid(fill_rsp_valid), .fill_rsp_frame(fill_rsp_frame),
        .fill_rsp_perm(fill_rsp_perm), .fill_rsp_global(fill_rsp_global),
        .main_wr(main_wr), .main_wr_flush(main_wr_flush), .inval_all(inval_all));

    utlb_cache #(.ENTRIES(4)) i_utlb_cache_instr (
        .clk(clk), .rst(rst), .lk_valid(lk_valid_s), .lk_vpage(lk_vpage), .lk_asid(lk_asid),
        .lk_hit(lk_hit_s), .lk_stall(lk_stall_s), .lk_frame(lk_frame_s), .lk_perm(lk_perm_s),
        .fill_req(fill_req_s), .fill_vpage(fill_vpage_s), .fill_asid(fill_asid_s),
        .fill_rsp_valid(fill_rsp_valid), .fill_rsp_frame(fill_rsp_frame),
        .fill_rsp_perm(fill_rsp_perm), .fill_rsp_global(fill_rsp_global),
        .main_wr(main_wr), .main_wr_flush(main_wr_flush), .inval_all(inval_all));

    wire        o_hit   = small_sel ? lk_hit_s   : lk_hit;
    wire        o_stall = small_sel ? lk_stall_s : lk_stall;
    wire        o_req   = small_sel ? fill_req_s : fill_req;
    wire [18:0] o_frame = small_sel ? lk_frame_s : lk_frame;
    wire [5:0]  o_perm  = small_sel ? lk_perm_s  : lk_perm;
    wire [18:0] o_fvp   = small_sel ? fill_vpage_s : fill_vpage;
    wire [7:0]  o_fas   = small_sel ? fill_asid_s  : fill_asid;

    function automatic logic [5:0] perm_of(logic [18:0] f);
        return f[5:0] ^ 6'h15;
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // One lookup; on a miss, answer the refill and confirm the follow-up hit.
    task automatic access(input logic [18:0] vp, input logic [7:0] as, input logic glb,
                          input logic [18:0] fr, input logic exp_hit, input logic sm,
                          input string rq);
        @(negedge clk);
        small_sel = sm;
        if (sm) lk_valid_s = 1'b1; else lk_valid = 1'b1;
        lk_vpage = vp; lk_asid = as;
        #1;
        chk(o_hit == exp_hit, rq, "lookup hit", 32'(o_hit), 32'(exp_hit));
        if (exp_hit) begin
            chk(o_frame == fr, rq, "hit frame", 32'(o_frame), 32'(fr));
            chk(o_perm == perm_of(fr), rq, "hit perm", 32'(o_perm), 32'(perm_of(fr)));
            chk(!o_stall, rq, "stall on hit", 32'(o_stall), 32'd0);
        end else begin
            chk(o_stall, "R4", "stall on miss", 32'(o_stall), 32'd1);
            @(negedge clk);
            chk(o_req && o_fvp == vp && o_fas == as, "R4", "refill request",
                {o_req, 4'd0, o_fvp, o_fas[7:0]} >> 8, {1'b1, 4'd0, vp, as} >> 8);
            fill_rsp_valid = 1'b1; fill_rsp_frame = fr;
            fill_rsp_perm = perm_of(fr); fill_rsp_global = glb;
            @(negedge clk);
            fill_rsp_valid = 1'b0;
            #1;
            chk(o_hit && o_frame == fr, "R4", "hit after refill", 32'(o_frame), 32'(fr));
            chk(!o_req, "R4", "request closed", 32'(o_req), 32'd0);
        end
        lk_valid = 1'b0; lk_valid_s = 1'b0;
    endtask

    task automatic pulse_cmd(input logic wr, input logic fl, input logic inv);
        @(negedge clk);
        main_wr = wr; main_wr_flush = fl; inval_all = inv;
        @(negedge clk);
        main_wr = 1'b0; main_wr_flush = 1'b0; inval_all = 1'b0;
    endtask

    // op: 0 lookup, 1 plain main write, 2 flushing main write, 3 invalidate
    typedef struct packed {
        logic [1:0]  op;
        logic [18:0] vp;
        logic [7:0]  asid;
        logic        glb;
        logic [18:0] frame;
        logic        exp_hit;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t TBL [NV] = '{
        '{2'd0, 19'h00100, 8'd5, 1'b0, 19'h00011, 1'b0, 4'd4},  // R4 first miss
        '{2'd0, 19'h00100, 8'd5, 1'b0, 19'h00011, 1'b1, 4'd2},  // R2 hit
        '{2'd0, 19'h00300, 8'd5, 1'b0, 19'h00022, 1'b0, 4'd4},
        '{2'd0, 19'h00500, 8'd5, 1'b0, 19'h00033, 1'b0, 4'd4},
        '{2'd1, 19'h00000, 8'd0, 1'b0, 19'h00000, 1'b0, 4'd6},  // R6 plain write
        '{2'd0, 19'h00100, 8'd5, 1'b0, 19'h00011, 1'b1, 4'd9},  // R9 three pages
        '{2'd0, 19'h00300, 8'd5, 1'b0, 19'h00022, 1'b1, 4'd6},
        '{2'd0, 19'h00500, 8'd5, 1'b0, 19'h00033, 1'b1, 4'd6},
        '{2'd0, 19'h00100, 8'd6, 1'b0, 19'h00044, 1'b0, 4'd3},  // R3 other ASID
        '{2'd0, 19'h00700, 8'd5, 1'b1, 19'h00055, 1'b0, 4'd3},
        '{2'd0, 19'h00700, 8'd9, 1'b0, 19'h00055, 1'b1, 4'd3},  // R3 global
        '{2'd0, 19'h00100, 8'd5, 1'b0, 19'h00011, 1'b1, 4'd3},
        '{2'd2, 19'h00000, 8'd0, 1'b0, 19'h00000, 1'b0, 4'd7},  // R7 flushing write
        '{2'd0, 19'h00500, 8'd5, 1'b0, 19'h00066, 1'b0, 4'd7},
        '{2'd3, 19'h00000, 8'd0, 1'b0, 19'h00000, 1'b0, 4'd7},  // R7 invalidate
        '{2'd0, 19'h00500, 8'd5, 1'b0, 19'h00077, 1'b0, 4'd7}
    };

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        lk_valid = 1'b1; lk_vpage = 19'h00100; lk_asid = 8'd5;
        #1;
        chk(!lk_hit, "R1", "hit after reset", 32'(lk_hit), 32'd0);
        chk(!fill_req && !fill_req_s, "R1", "request after reset", 32'(fill_req), 32'd0);
        lk_valid = 1'b0;

        for (int i = 0; i < NV; i++) begin
            string rq;
            rq = $sformatf("R%0d", TBL[i].req);
            case (TBL[i].op)
                2'd0: access(TBL[i].vp, TBL[i].asid, TBL[i].glb, TBL[i].frame,
                             TBL[i].exp_hit, 1'b0, rq);
                2'd1: pulse_cmd(1'b1, 1'b0, 1'b0);
                2'd2: pulse_cmd(1'b1, 1'b1, 1'b0);
                default: pulse_cmd(1'b0, 1'b0, 1'b1);
            endcase
        end

        // R5: round-robin replacement
        pulse_cmd(1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 9; i++)
            access(19'h01000 + 19'(i), 8'd2, 1'b0, 19'h00200 + 19'(i), 1'b0, 1'b0, "R5");
        access(19'h01000, 8'd2, 1'b0, 19'h00300, 1'b0, 1'b0, "R5");  // oldest evicted
        access(19'h01002, 8'd2, 1'b0, 19'h00202, 1'b1, 1'b0, "R5");
        access(19'h01008, 8'd2, 1'b0, 19'h00208, 1'b1, 1'b0, "R5");

        // R8: flush coinciding with refill response
        @(negedge clk);
        small_sel = 1'b0;
        lk_valid = 1'b1; lk_vpage = 19'h02222; lk_asid = 8'd1;
        @(negedge clk);
        fill_rsp_valid = 1'b1; fill_rsp_frame = 19'h00abc;
        fill_rsp_perm = perm_of(19'h00abc); fill_rsp_global = 1'b0;
        inval_all = 1'b1;
        @(negedge clk);
        fill_rsp_valid = 1'b0; inval_all = 1'b0;
        #1;
        chk(!lk_hit && lk_stall, "R8", "response discarded", 32'(lk_hit), 32'd0);
        @(negedge clk);
        #1;
        chk(fill_req && fill_vpage == 19'h02222, "R8", "request reissued", 32'(fill_req), 32'd1);
        fill_rsp_valid = 1'b1; fill_rsp_frame = 19'h00abd; fill_rsp_perm = perm_of(19'h00abd);
        @(negedge clk);
        fill_rsp_valid = 1'b0;
        #1;
        chk(lk_hit && lk_frame == 19'h00abd, "R8", "second refill hits", 32'(lk_frame), 32'h00abd);
        lk_valid = 1'b0;

        // R9: 4-entry instance
        pulse_cmd(1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 5; i++)
            access(19'h03000 + 19'(i), 8'd3, 1'b0, 19'h00400 + 19'(i), 1'b0, 1'b1, "R9");
        access(19'h03002, 8'd3, 1'b0, 19'h00402, 1'b1, 1'b1, "R9");
        access(19'h03000, 8'd3, 1'b0, 19'h00410, 1'b0, 1'b1, "R9");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule